// File: doc/BRIEF.md
# Synchronous Dual-Port Byte-Lane RAM

This block is a true dual-port static memory of 4096 words by 18 bits with two fully independent access ports, A and B, sharing one clock. On any rising edge each port may read or write any word, including the same word the other port is touching. Each port carries its own address, write data, read data, read/write select, a pair of chip enables of opposite polarity, two active-low byte-lane enables that split the word into 9-bit halves, an active-low output enable and a latency select pin.

The latency select picks, per port, between a flow-through read path (data follows the edge that captures the address) and a pipelined path (one extra register stage). A disabled or invalid read is signalled through a per-port valid flag, and the read data is driven to zero whenever the flag is low, standing in for a high-impedance bus.

Top module: `dualPortRam`

## Requirements
- R1: While reset is low, and after it until the first read, both valid flags are low and both read-data buses are zero.
- R2: A port is selected only when its chip enable 0 (active low) is 0 and its chip enable 1 (active high) is 1; an unselected edge writes nothing and produces no valid read.
- R3: A selected edge with read/write select 0 is a write: upper-lane enable 0 stores data bits 17..9, lower-lane enable 0 stores bits 8..0, a lane whose enable is 1 keeps its old contents.
- R4: With the latency pin 0 (flow-through), a selected edge with read/write select 1 makes the addressed word appear on read data, with valid 1, in the cycle right after that edge.
- R5: With the latency pin 1 (pipelined), that word appears with valid 1 in the cycle after the following edge.
- R6: Output enable 1 forces that port's valid to 0 and its read data to zero in the same cycle, whatever the read state.
- R7: A read of a word that the other port writes on the same edge returns the old contents; the new contents are read from the next edge on.
- R8: When both ports write the same word on the same edge, port A's data wins on each lane both enable, and each lane only one port enables takes that port's data.
- R9: In pipelined mode, an edge that is a deselect or a write leaves the output cycle one edge later invalid; in flow-through mode such an edge makes the very next cycle invalid.
- R10: The two ports operate concurrently, each with its own latency setting, and one port's traffic never changes the other's read timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge active |
| rstN | input | 1 | Asynchronous reset of the output registers, active low |
| aAddr | input | 12 | Port A word address |
| aWrData | input | 18 | Port A write data |
| aRdData | output | 18 | Port A read data, zero when not valid |
| aRwN | input | 1 | Port A read (1) or write (0) |
| aCe0N | input | 1 | Port A chip enable, active low |
| aCe1 | input | 1 | Port A chip enable, active high |
| aUbN | input | 1 | Port A upper lane (bits 17..9) enable, active low |
| aLbN | input | 1 | Port A lower lane (bits 8..0) enable, active low |
| aOeN | input | 1 | Port A output enable, active low |
| aPipe | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| aValid | output | 1 | Port A read data valid |
| bAddr | input | 12 | Port B word address |
| bWrData | input | 18 | Port B write data |
| bRdData | output | 18 | Port B read data, zero when not valid |
| bRwN | input | 1 | Port B read (1) or write (0) |
| bCe0N | input | 1 | Port B chip enable, active low |
| bCe1 | input | 1 | Port B chip enable, active high |
| bUbN | input | 1 | Port B upper lane enable, active low |
| bLbN | input | 1 | Port B lower lane enable, active low |
| bOeN | input | 1 | Port B output enable, active low |
| bPipe | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| bValid | output | 1 | Port B read data valid |

## Verification
A flow-through read is due one edge after the address is captured and a pipelined read two edges after, while output enable and the latency pin act within the current cycle and writes become readable one edge later. The bench drives all pins at the falling edge and compares both ports at the next falling edge, before driving again, against a bench model whose per-port stage registers advance once per drive step. That model performs every read before the same step's writes, and applies port B's lanes before port A's, so collision results follow the requirements rather than the RTL.

// File: rtl/dpramPkg.sv
package dpramPkg;

  // strobes from a port's control to the shared datapath
  typedef struct packed {
    logic wrHi;     // store upper lane this edge
    logic wrLo;     // store lower lane this edge
    logic rdEn;     // capture the addressed word this edge
    logic usePipe;  // present the second stage instead of the first
    logic drive;    // read bus carries data this cycle
  } portStrobe_t;

  localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpramCtrl.sv
module dpramCtrl
  import dpramPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ce0N,
  input  logic        ce1,
  input  logic        rwN,
  input  logic        ubN,
  input  logic        lbN,
  input  logic        oeN,
  input  logic        pipeMode,
  output portStrobe_t strobe,
  output logic        outValid
);

  logic portSel;
  logic firstValid;
  logic secondValid;

  assign portSel = !ce0N && ce1;

  always_comb begin
    strobe.wrHi    = portSel && !rwN && !ubN;
    strobe.wrLo    = portSel && !rwN && !lbN;
    strobe.rdEn    = portSel && rwN;
    strobe.usePipe = pipeMode;
    strobe.drive   = !oeN && (pipeMode ? secondValid : firstValid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstValid  <= 1'b0;
      secondValid <= 1'b0;
    end else begin
      firstValid  <= strobe.rdEn;
      secondValid <= firstValid;
    end
  end

  assign outValid = strobe.drive;

endmodule

// File: rtl/dpramArray.sv
module dpramArray
  import dpramPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr   [NUM_PORTS],
  input  logic [DATA_W-1:0] wrData [NUM_PORTS],
  input  portStrobe_t       strobe [NUM_PORTS],
  output logic [DATA_W-1:0] rdData [NUM_PORTS]
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] store [DEPTH];

  // highest port index first, so port 0 (A) lands last and wins a shared lane
  always_ff @(posedge clk) begin
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (strobe[p].wrHi)
        store[addr[p]][DATA_W-1:LANE_W] <= wrData[p][DATA_W-1:LANE_W];
      if (strobe[p].wrLo)
        store[addr[p]][LANE_W-1:0] <= wrData[p][LANE_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_readPath
    logic [DATA_W-1:0] stageOne;
    logic [DATA_W-1:0] stageTwo;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageOne <= '0;
        stageTwo <= '0;
      end else begin
        if (strobe[p].rdEn) stageOne <= store[addr[p]];
        stageTwo <= stageOne;
      end
    end

    assign rdData[p] = !strobe[p].drive ? '0 :
                       (strobe[p].usePipe ? stageTwo : stageOne);
  end

endmodule

// File: rtl/dualPortRam.sv
module dualPortRam
  import dpramPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  input  logic              aRwN,
  input  logic              aCe0N,
  input  logic              aCe1,
  input  logic              aUbN,
  input  logic              aLbN,
  input  logic              aOeN,
  input  logic              aPipe,
  output logic              aValid,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  input  logic              bRwN,
  input  logic              bCe0N,
  input  logic              bCe1,
  input  logic              bUbN,
  input  logic              bLbN,
  input  logic              bOeN,
  input  logic              bPipe,
  output logic              bValid
);

  logic [ADDR_W-1:0] addrArr   [NUM_PORTS];
  logic [DATA_W-1:0] wrArr     [NUM_PORTS];
  logic [DATA_W-1:0] rdArr     [NUM_PORTS];
  logic              rwArr     [NUM_PORTS];
  logic              ce0Arr    [NUM_PORTS];
  logic              ce1Arr    [NUM_PORTS];
  logic              ubArr     [NUM_PORTS];
  logic              lbArr     [NUM_PORTS];
  logic              oeArr     [NUM_PORTS];
  logic              pipeArr   [NUM_PORTS];
  logic              validArr  [NUM_PORTS];
  portStrobe_t       strobeArr [NUM_PORTS];

  assign addrArr[0] = aAddr;    assign addrArr[1] = bAddr;
  assign wrArr[0]   = aWrData;  assign wrArr[1]   = bWrData;
  assign rwArr[0]   = aRwN;     assign rwArr[1]   = bRwN;
  assign ce0Arr[0]  = aCe0N;    assign ce0Arr[1]  = bCe0N;
  assign ce1Arr[0]  = aCe1;     assign ce1Arr[1]  = bCe1;
  assign ubArr[0]   = aUbN;     assign ubArr[1]   = bUbN;
  assign lbArr[0]   = aLbN;     assign lbArr[1]   = bLbN;
  assign oeArr[0]   = aOeN;     assign oeArr[1]   = bOeN;
  assign pipeArr[0] = aPipe;    assign pipeArr[1] = bPipe;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ctrl
    dpramCtrl uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .ce0N     (ce0Arr[p]),
      .ce1      (ce1Arr[p]),
      .rwN      (rwArr[p]),
      .ubN      (ubArr[p]),
      .lbN      (lbArr[p]),
      .oeN      (oeArr[p]),
      .pipeMode (pipeArr[p]),
      .strobe   (strobeArr[p]),
      .outValid (validArr[p])
    );
  end

  dpramArray #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uArray (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addrArr),
    .wrData (wrArr),
    .strobe (strobeArr),
    .rdData (rdArr)
  );

  assign aRdData = rdArr[0];
  assign bRdData = rdArr[1];
  assign aValid  = validArr[0];
  assign bValid  = validArr[1];

endmodule

// File: rtl/dpramChecker.sv
module dpramChecker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              aRwN,
  input logic              aCe0N,
  input logic              aCe1,
  input logic              aOeN,
  input logic              aPipe,
  input logic              aValid,
  input logic [DATA_W-1:0] aRdData,
  input logic              bRwN,
  input logic              bCe0N,
  input logic              bCe1,
  input logic              bOeN,
  input logic              bPipe,
  input logic              bValid,
  input logic [DATA_W-1:0] bRdData
);

  logic aRead;
  logic bRead;
  assign aRead = !aCe0N && aCe1 && aRwN;
  assign bRead = !bCe0N && bCe1 && bRwN;

  // R1: reset clears the output stage
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!aValid && !bValid && aRdData == '0 && bRdData == '0));

  // R6: output enable high blanks the port
  p_oe_blank_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    aOeN |-> (!aValid && aRdData == '0));
  p_oe_blank_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    bOeN |-> (!bValid && bRdData == '0));
  p_invalid_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!aValid |-> aRdData == '0) and (!bValid |-> bRdData == '0));

  // R4: flow-through read valid one edge later
  p_ft_latency_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    aRead |=> (aOeN || aPipe || aValid));
  p_ft_latency_b_r4: assert property (@(posedge clk) disable iff (!rstN)
    bRead |=> (bOeN || bPipe || bValid));

  // R5: pipelined read valid two edges later
  p_pipe_latency_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    aRead |-> ##2 (aOeN || !aPipe || aValid));
  p_pipe_latency_b_r5: assert property (@(posedge clk) disable iff (!rstN)
    bRead |-> ##2 (bOeN || !bPipe || bValid));

  // R9: a non-read edge leaves a gap in the output stream
  p_pipe_gap_a_r9: assert property (@(posedge clk) disable iff (!rstN)
    !aRead |-> ##2 (!aPipe || !aValid));
  p_ft_gap_a_r9: assert property (@(posedge clk) disable iff (!rstN)
    !aRead |=> (aPipe || !aValid));
  p_pipe_gap_b_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bRead |-> ##2 (!bPipe || !bValid));
  p_ft_gap_b_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bRead |=> (bPipe || !bValid));

endmodule

bind dualPortRam dpramChecker #(.DATA_W(DATA_W)) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .aRwN    (aRwN),
  .aCe0N   (aCe0N),
  .aCe1    (aCe1),
  .aOeN    (aOeN),
  .aPipe   (aPipe),
  .aValid  (aValid),
  .aRdData (aRdData),
  .bRwN    (bRwN),
  .bCe0N   (bCe0N),
  .bCe1    (bCe1),
  .bOeN    (bOeN),
  .bPipe   (bPipe),
  .bValid  (bValid),
  .bRdData (bRdData)
);

// File: tb/dualPortRam_test.sv
module dualPortRam_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 18;
  localparam int LW = DW / 2;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // pins currently applied
  logic [AW-1:0] pAddr [2];
  logic [DW-1:0] pData [2];
  logic          pRwN  [2];
  logic          pCe0N [2];
  logic          pCe1  [2];
  logic          pUbN  [2];
  logic          pLbN  [2];
  logic          pOeN  [2];
  logic          pPipe [2];
  // pins to apply on the next step
  logic [AW-1:0] nAddr [2];
  logic [DW-1:0] nData [2];
  logic          nRwN  [2];
  logic          nCe0N [2];
  logic          nCe1  [2];
  logic          nUbN  [2];
  logic          nLbN  [2];
  logic          nOeN  [2];
  logic          nPipe [2];

  logic [DW-1:0] aRdData, bRdData;
  logic          aValid, bValid;

  dualPortRam uut (
    .clk(clk), .rstN(rstN),
    .aAddr(pAddr[0]), .aWrData(pData[0]), .aRdData(aRdData), .aRwN(pRwN[0]),
    .aCe0N(pCe0N[0]), .aCe1(pCe1[0]), .aUbN(pUbN[0]), .aLbN(pLbN[0]),
    .aOeN(pOeN[0]), .aPipe(pPipe[0]), .aValid(aValid),
    .bAddr(pAddr[1]), .bWrData(pData[1]), .bRdData(bRdData), .bRwN(pRwN[1]),
    .bCe0N(pCe0N[1]), .bCe1(pCe1[1]), .bUbN(pUbN[1]), .bLbN(pLbN[1]),
    .bOeN(pOeN[1]), .bPipe(pPipe[1]), .bValid(bValid)
  );

  // bench model
  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] s1 [2];
  logic [DW-1:0] s2 [2];
  logic          fv [2];
  logic          pv [2];

  int    nChecks = 0;
  int    nFails  = 0;
  string tag     = "R1";
  bit    done    = 0;

  task automatic check(input string t, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic logic expValid(input int p);
    return !pOeN[p] && (pPipe[p] ? pv[p] : fv[p]);
  endfunction

  function automatic logic [DW-1:0] expData(input int p);
    if (!expValid(p)) return '0;
    return pPipe[p] ? s2[p] : s1[p];
  endfunction

  task automatic modelStep();
    logic rd [2];
    logic [DW-1:0] old [2];
    for (int p = 0; p < 2; p++) begin
      rd[p]  = !pCe0N[p] && pCe1[p] && pRwN[p];
      old[p] = model[pAddr[p]];
    end
    for (int p = 0; p < 2; p++) begin
      pv[p] = fv[p];
      fv[p] = rd[p];
      s2[p] = s1[p];
      if (rd[p]) s1[p] = old[p];
    end
    // B first, A last: A wins shared lanes
    for (int p = 1; p >= 0; p--) begin
      if (!pCe0N[p] && pCe1[p] && !pRwN[p]) begin
        if (!pUbN[p]) model[pAddr[p]][DW-1:LW] = pData[p][DW-1:LW];
        if (!pLbN[p]) model[pAddr[p]][LW-1:0]  = pData[p][LW-1:0];
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(tag, "A data",  aRdData, expData(0));
    check(tag, "A valid", {{(DW-1){1'b0}}, aValid}, {{(DW-1){1'b0}}, expValid(0)});
    check(tag, "B data",  bRdData, expData(1));
    check(tag, "B valid", {{(DW-1){1'b0}}, bValid}, {{(DW-1){1'b0}}, expValid(1)});
    for (int p = 0; p < 2; p++) begin
      pAddr[p] = nAddr[p]; pData[p] = nData[p]; pRwN[p] = nRwN[p];
      pCe0N[p] = nCe0N[p]; pCe1[p] = nCe1[p]; pUbN[p] = nUbN[p];
      pLbN[p] = nLbN[p];   pOeN[p] = nOeN[p]; pPipe[p] = nPipe[p];
    end
    modelStep();
  endtask

  task automatic idle(input int p);
    nCe0N[p] = 1'b1; nCe1[p] = 1'b0; nRwN[p] = 1'b1;
    nUbN[p] = 1'b1;  nLbN[p] = 1'b1;
  endtask

  task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic ub, input logic lb);
    nCe0N[p] = 1'b0; nCe1[p] = 1'b1; nRwN[p] = 1'b0;
    nAddr[p] = a; nData[p] = d; nUbN[p] = ub; nLbN[p] = lb;
  endtask

  task automatic rd(input int p, input logic [AW-1:0] a);
    nCe0N[p] = 1'b0; nCe1[p] = 1'b1; nRwN[p] = 1'b1;
    nAddr[p] = a; nUbN[p] = 1'b1; nLbN[p] = 1'b1;
  endtask

  task automatic settle();
    idle(0); idle(1);
    tick(); tick(); tick();
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 2; p++) begin
      s1[p] = '0; s2[p] = '0; fv[p] = 1'b0; pv[p] = 1'b0;
      nAddr[p] = '0; nData[p] = '0; nOeN[p] = 1'b0; nPipe[p] = 1'b0;
      idle(p);
      pAddr[p] = '0; pData[p] = '0; pRwN[p] = 1'b1; pCe0N[p] = 1'b1;
      pCe1[p] = 1'b0; pUbN[p] = 1'b1; pLbN[p] = 1'b1; pOeN[p] = 1'b0; pPipe[p] = 1'b0;
    end
    // R1: outputs quiet in and after reset
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "A data in reset", aRdData, '0);
    check("R1", "B data in reset", bRdData, '0);
    rstN = 1'b1;
    tick(); tick();

    // R3: fill the used words, full words from both ports
    tag = "R3";
    for (int i = 0; i < 8; i++) begin
      wr(0, AW'(i), DW'(18'h1000 + i * 18'h0111), 1'b0, 1'b0);
      wr(1, AW'(4095 - i), DW'(18'h2a000 + i), 1'b0, 1'b0);
      tick();
    end
    // R3: lane writes
    wr(0, 12'd1, 18'h3ffff, 1'b0, 1'b1); idle(1); tick();   // upper lane only
    wr(1, 12'd2, 18'h3ffff, 1'b1, 1'b0); idle(0); tick();   // lower lane only
    wr(0, 12'd5, 18'h3ffff, 1'b1, 1'b1); idle(1); tick();   // no lane: no change
    tag = "R4";
    rd(0, 12'd1); rd(1, 12'd2); tick();
    rd(0, 12'd5); rd(1, 12'd1); tick();
    settle();

    // R7: read during the other port's write returns old contents
    tag = "R7";
    wr(0, 12'd3, 18'h15555, 1'b0, 1'b0); rd(1, 12'd3); tick();
    idle(0); rd(1, 12'd3); tick();
    wr(1, 12'd6, 18'h0abcd, 1'b0, 1'b0); rd(0, 12'd6); tick();
    rd(0, 12'd6); idle(1); tick();
    settle();

    // R8: both ports write one word
    tag = "R8";
    wr(0, 12'd4, 18'h11111, 1'b0, 1'b0); wr(1, 12'd4, 18'h22222, 1'b0, 1'b0); tick();
    wr(0, 12'd7, 18'h3f0f0, 1'b0, 1'b1); wr(1, 12'd7, 18'h00f0f, 1'b0, 1'b0); tick();
    rd(0, 12'd4); rd(1, 12'd7); tick();
    settle();

    // R2: either chip enable inactive blocks the write and the read
    tag = "R2";
    wr(0, 12'd4, 18'h0dead, 1'b0, 1'b0); nCe0N[0] = 1'b1;
    rd(1, 12'd4); nCe1[1] = 1'b0; tick();
    wr(1, 12'd7, 18'h0beef, 1'b0, 1'b0); nCe1[1] = 1'b0;
    rd(0, 12'd7); nCe0N[0] = 1'b1; tick();
    rd(0, 12'd4); rd(1, 12'd7); tick();
    settle();

    // R6: output enable blanks an otherwise valid read
    tag = "R6";
    rd(0, 12'd1); rd(1, 12'd2); nOeN[0] = 1'b1; tick();
    idle(0); idle(1); tick();
    nOeN[0] = 1'b0; nOeN[1] = 1'b1; tick();
    nOeN[1] = 1'b0; settle();

    // R5 / R9: pipelined reads with gaps
    tag = "R5";
    nPipe[0] = 1'b1; nPipe[1] = 1'b1; settle();
    rd(0, 12'd0); rd(1, 12'd4095); tick();
    rd(0, 12'd3); idle(1); tick();
    tag = "R9";
    idle(0); rd(1, 12'd4094); tick();
    wr(0, 12'd0, 18'h00077, 1'b1, 1'b0); wr(1, 12'd4095, 18'h1, 1'b0, 1'b0); tick();
    rd(0, 12'd0); rd(1, 12'd4095); tick();
    settle();

    // R10: random concurrent traffic, per-port latency
    tag = "R10";
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int p = 0; p < 2; p++) begin
        logic [AW-1:0] a;
        a = ($urandom % 9 == 8) ? AW'(4095) : AW'($urandom % 8);
        if (cyc % 97 == 0) nPipe[p] = 1'($urandom);
        nOeN[p] = ($urandom % 7 == 0);
        if ($urandom % 2 == 0) rd(p, a);
        else wr(p, a, DW'($urandom), 1'($urandom), 1'($urandom));
        nCe0N[p] = ($urandom % 6 == 0);
        nCe1[p]  = ($urandom % 6 != 0);
      end
      tick();
    end
    settle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule